// File: doc/BRIEF.md
# Zero-Page Bank Select Registers

This block watches an 8-bit CPU bus with a 16-bit address, a read/write strobe and the PHI2 bus clock. It keeps two byte-wide bank-select registers that the CPU reaches as ordinary writable bytes at the two lowest addresses of zero page. One register drives the upper address lines of banked RAM. The other drives the upper address lines of banked ROM.

The block has its own decode. An address whose bits 15 down to 1 are all zero, with a write on the strobe, qualifies as a hit. Address bit 0 and the PHI2 level then pick one line of a four-way decoder. Only the two lines taken while PHI2 is high produce a load enable. The chosen register takes the data bus on the next rising edge of the system clock `clk`. Address and strobe settle during the low phase, and a capture happens only in the high phase.

An active-low reset clears both registers at once, so ROM bank 0 is selected at boot. The outputs are always driven. Reads of the two addresses are left to other logic, and no other select waits on this decode.

Top module: `zp_bank_decoder`

## Requirements
- R1: While `rst_n` is low, both `ram_bank` and `rom_bank` read 8'h00, without waiting for a clock edge.
- R2: If `phi2`=1, `cpu_rw`=0 and `cpu_addr`=16'h0000 at a rising `clk` edge, `ram_bank` equals the `cpu_data` sampled at that edge after the edge.
- R3: If `phi2`=1, `cpu_rw`=0 and `cpu_addr`=16'h0001 at a rising `clk` edge, `rom_bank` equals the `cpu_data` sampled at that edge after the edge.
- R4: If any of `cpu_addr[15:1]` is 1 at an edge, neither output changes at that edge.
- R5: If `cpu_rw`=1 (read) at an edge, neither output changes, including for reads of 16'h0000 and 16'h0001.
- R6: If `phi2`=0 at an edge, neither output changes, even when the address and strobe describe a qualifying write.
- R7: A load of one register leaves the other register unchanged.
- R8: With no qualifying write, each output keeps its last loaded value across any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2 | input | 1 | CPU bus clock level; captures only while high |
| cpu_addr | input | 16 | CPU address bus |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_data | input | 8 | CPU data bus, the value captured on a load |
| ram_bank | output | 8 | Register at address 16'h0000, drives the RAM bank lines |
| rom_bank | output | 8 | Register at address 16'h0001, drives the ROM bank lines |

## Verification
Every cycle, the assertions check the load of each register from the data bus. They also check that the outputs hold when the address is too high, when the access is a read, or when PHI2 is low, and that at most one decoder line is active. Only the bench scenarios show the immediate clearing by an asynchronous reset in the middle of a run. They also show that values persist over long idle stretches and that the outputs match a reference across mixed random traffic that is biased toward the two register addresses.

// File: rtl/zpb_pkg.sv
package zpb_pkg;
  // Four decoder slots, indexed by {phi2, a0}
  localparam int unsigned SLOT_N = 4;
  // Slots at or above this index are taken during the PHI2 high phase
  localparam int unsigned SLOT_HI_BASE = 2;
  localparam int unsigned BANK_N = 2;
  // Register index of each bank (equal to the value of address bit 0)
  localparam int unsigned IDX_RAM = 0;
  localparam int unsigned IDX_ROM = 1;
endpackage

// File: rtl/zpb_addr_match.sv
module zpb_addr_match #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw,
  output logic              hit
);
  // Upper address bits all zero and a write cycle
  always_comb hit = ~(|addr[ADDR_W-1:1]) & ~rw;
endmodule

// File: rtl/zpb_slot_demux.sv
module zpb_slot_demux
  import zpb_pkg::*;
(
  input  logic              en,
  input  logic              phi2,
  input  logic              a0,
  output logic [SLOT_N-1:0] line
);
  localparam int unsigned SEL_W = $clog2(SLOT_N);
  logic [SEL_W-1:0] sel;
  always_comb sel = {phi2, a0};

  for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
    always_comb line[s] = en && (sel == SEL_W'(s));
  end
endmodule

// File: rtl/zpb_bank_reg.sv
module zpb_bank_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/zp_bank_decoder.sv
module zp_bank_decoder
  import zpb_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phi2,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_rw,
  input  logic [DATA_W-1:0] cpu_data,
  output logic [DATA_W-1:0] ram_bank,
  output logic [DATA_W-1:0] rom_bank
);
  logic              zp_hit;
  logic [SLOT_N-1:0] dec_line;
  logic [DATA_W-1:0] bank_q [BANK_N];

  zpb_addr_match #(.ADDR_W(ADDR_W)) i_match (
    .addr (cpu_addr),
    .rw   (cpu_rw),
    .hit  (zp_hit)
  );

  zpb_slot_demux i_demux (
    .en   (zp_hit),
    .phi2 (phi2),
    .a0   (cpu_addr[0]),
    .line (dec_line)
  );

  for (genvar b = 0; b < BANK_N; b++) begin : g_bank
    zpb_bank_reg #(.DATA_W(DATA_W)) i_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (dec_line[SLOT_HI_BASE+b]),
      .d     (cpu_data),
      .q     (bank_q[b])
    );
  end

  assign ram_bank = bank_q[IDX_RAM];
  assign rom_bank = bank_q[IDX_ROM];

  // Assertions
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEARS: assert (ram_bank == '0 && rom_bank == '0); // R1
    end
  end

  AST_RAM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (phi2 && !cpu_rw && cpu_addr == ADDR_W'(0)) |=> ram_bank == $past(cpu_data)); // R2

  AST_ROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (phi2 && !cpu_rw && cpu_addr == ADDR_W'(1)) |=> rom_bank == $past(cpu_data)); // R3

  AST_FAR_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (|cpu_addr[ADDR_W-1:1]) |=> $stable(ram_bank) && $stable(rom_bank)); // R4

  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rw |=> $stable(ram_bank) && $stable(rom_bank)); // R5

  AST_LOW_PHASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !phi2 |=> $stable(ram_bank) && $stable(rom_bank)); // R6

  AST_RAM_LOAD_SPARES_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    (phi2 && !cpu_rw && cpu_addr == ADDR_W'(0)) |=> $stable(rom_bank)); // R7

  AST_ROM_LOAD_SPARES_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    (phi2 && !cpu_rw && cpu_addr == ADDR_W'(1)) |=> $stable(ram_bank)); // R7

  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dec_line)); // R7
endmodule

// File: tb/test_zp_bank_decoder.sv
module test_zp_bank_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phi2 = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rw = 1'b1;
  logic [7:0]  cpu_data = '0;
  logic [7:0]  ram_bank, rom_bank;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_ram = '0;
  logic [7:0] exp_rom = '0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  zp_bank_decoder i_zp_bank_decoder (
    .clk(clk), .rst_n(rst_n), .phi2(phi2), .cpu_addr(cpu_addr),
    .cpu_rw(cpu_rw), .cpu_data(cpu_data), .ram_bank(ram_bank), .rom_bank(rom_bank)
  );

  // Reference: does this bus state load the register at address idx?
  function automatic bit loads(input logic p, input logic rw, input logic [15:0] a, input int idx);
    return p && !rw && (a == 16'(idx));
  endfunction

  task automatic check(input string req, input logic [7:0] act_ram, input logic [7:0] act_rom);
    checks++;
    if (act_ram !== exp_ram || act_rom !== exp_rom) begin
      errors++;
      $display("FAIL %s: ram=%h rom=%h expected ram=%h rom=%h", req, act_ram, act_rom, exp_ram, exp_rom);
    end
  endtask

  // Drive after a falling edge, let one rising edge pass, check at the next falling edge
  task automatic bus(input logic p, input logic rw, input logic [15:0] a, input logic [7:0] d, input string req);
    phi2 = p; cpu_rw = rw; cpu_addr = a; cpu_data = d;
    if (loads(p, rw, a, 0)) exp_ram = d;
    if (loads(p, rw, a, 1)) exp_rom = d;
    @(negedge clk);
    check(req, ram_bank, rom_bank);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check("R1 reset state", ram_bank, rom_bank);
    rst_n = 1'b1;
    @(negedge clk);

    bus(1, 0, 16'h0000, 8'hA5, "R2 load ram");
    bus(1, 0, 16'h0001, 8'h3C, "R3 load rom, R7 ram kept");
    bus(1, 0, 16'h0000, 8'h11, "R7 ram load keeps rom");
    bus(0, 0, 16'h0000, 8'hFF, "R6 phi2 low ram");
    bus(0, 0, 16'h0001, 8'hFF, "R6 phi2 low rom");
    bus(1, 1, 16'h0000, 8'hEE, "R5 read of 0000");
    bus(1, 1, 16'h0001, 8'hEE, "R5 read of 0001");
    bus(1, 0, 16'h8000, 8'h77, "R4 top bit set");
    bus(1, 0, 16'h0002, 8'h77, "R4 bit1 set");
    bus(1, 0, 16'h0003, 8'h77, "R4 address 0003");
    for (int k = 0; k < 20; k++) bus(0, 1, 16'hFFFF, 8'h00, "R8 idle hold");

    for (int n = 0; n < 2000; n++) begin
      int unsigned pick = $urandom_range(0, 3);
      logic [15:0] a;
      a = (pick == 0) ? 16'h0000 : (pick == 1) ? 16'h0001 : 16'($urandom());
      if (pick == 2) a = {15'($urandom_range(1, 3)), a[0]};
      bus(1'($urandom()), 1'($urandom()), a, 8'($urandom()), "R2 R3 R4 R5 R6 random");
    end

    // Asynchronous reset part-way through the low half of the clock
    bus(1, 0, 16'h0001, 8'h9A, "R3 preload");
    #1 rst_n = 1'b0;
    #0.5;
    exp_ram = '0; exp_rom = '0;
    check("R1 async clear", ram_bank, rom_bank);
    @(negedge clk);
    rst_n = 1'b1;
    bus(1, 0, 16'h0000, 8'h5A, "R2 after reset");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule